// File: doc/BRIEF.md
# Host Controller Interrupt Register Unit

This block holds the interrupt state of a host-controller register file. Single-cycle event pulses from the controller core land in sticky status bits. Software sees those bits through a status word and removes them by writing ones back.

Interrupt sources are unmasked through two word addresses. One sets bits in the mask and the other removes them. Both addresses read back the same mask. The top bit of the mask is a master gate over every source. A single level-sensitive interrupt line goes high while that gate is open and at least one pending status bit has its mask bit set.

The bus side is a plain word-indexed register port with no wait states. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register contents. There is no state machine: each register updates on its own at every edge.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset, the status word and the enable mask are all zero and `irq` is low.
- R2: A one-cycle pulse on an implemented source line sets the matching status bit at the next clock edge, whatever the enable mask holds.
- R3: Writing at word index 0 (status) clears every status bit written as one. Bits written as zero are left unchanged.
- R4: If a status bit is written as one in the same cycle that its source pulses, the bit ends up set.
- R5: Writing at word index 1 (mask set) sets every implemented mask bit written as one. Bits written as zero are left unchanged.
- R6: Writing at word index 2 (mask clear) clears every mask bit written as one. Bits written as zero are left unchanged.
- R7: Reads at word index 1 and word index 2 both return the current enable mask.
- R8: `irq` is high exactly when mask bit 31 (master gate) is one and some status bit is one whose mask bit is also one.
- R9: Status bit 31 and every unimplemented bit read as zero, and writes and pulses on them have no effect. Word index 3 reads zero and ignores writes.
- R10: The implemented source bits are 0 (scheduling overrun), 1 (done list written back), 2 (frame start), 3 (resume seen), 4 (fatal error), 5 (frame counter wrap), 6 (port change) and 30 (ownership change). The implemented source mask is therefore 0x4000007F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Word index: 0 status, 1 mask set, 2 mask clear, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_pulse | input | 32 | Event pulses, one per bit position |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions take for granted that `bus_addr`, `bus_wr`, `bus_wdata` and `evt_pulse` are stable around the sampling edge, and that a write always names a single word index. The bench drives every input at the falling edge and holds it for one full cycle. It returns the strobes to zero before the next operation, so each event pulse lasts exactly one cycle. Every bit position, including the unimplemented ones and bit 31, is swept one at a time. Each is pushed both through the event lines and through all four word indices.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MSET   = 2'd1,
        SEL_MCLR   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    localparam logic [WORD_W-1:0] SRC_DEFAULT = 32'h4000_007F;
    localparam int unsigned       GATE_BIT    = 31;
endpackage

// File: rtl/hc_irq_decode.sv
module hc_irq_decode
    import hc_irq_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [SEL_W-1:0] addr,
    input  logic             wr,
    input  logic [W-1:0]     stat_q,
    input  logic [W-1:0]     mask_q,
    output logic             wr_status,
    output logic             wr_mset,
    output logic             wr_mclr,
    output logic [W-1:0]     rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_comb begin
        wr_status = 1'b0;
        wr_mset   = 1'b0;
        wr_mclr   = 1'b0;
        rdata     = '0;
        unique case (sel)
            SEL_STATUS: begin
                wr_status = wr;
                rdata     = stat_q;
            end
            SEL_MSET: begin
                wr_mset = wr;
                rdata   = mask_q;
            end
            SEL_MCLR: begin
                wr_mclr = wr;
                rdata   = mask_q;
            end
            SEL_SPARE: begin
                rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
    parameter int unsigned     W        = 32,
    parameter logic [W-1:0]    SRC_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] stat_d;

    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
        // a fresh event overrides a clear in the same cycle
        stat_d  = ((stat_q & ~clr_vec) | evt) & SRC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/hc_irq_mask.sv
module hc_irq_mask #(
    parameter int unsigned  W       = 32,
    parameter logic [W-1:0] EN_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_q
);
    logic [W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_en) mask_d = mask_d | bits;
        if (clr_en) mask_d = mask_d & ~bits;
        mask_d = mask_d & EN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
    import hc_irq_pkg::*;
#(
    parameter int unsigned     W        = WORD_W,
    parameter int unsigned     GATE     = GATE_BIT,
    parameter logic [W-1:0]    SRC_MASK = SRC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     evt_pulse,
    output logic             irq
);
    localparam logic [W-1:0] GATE_ONEHOT = W'(1) << GATE;
    localparam logic [W-1:0] SRC_ONLY    = SRC_MASK & ~GATE_ONEHOT;
    localparam logic [W-1:0] EN_MASK     = SRC_ONLY | GATE_ONEHOT;

    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;
    logic         wr_status;
    logic         wr_mset;
    logic         wr_mclr;

    hc_irq_decode #(.W(W)) u_dec (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .wr_status (wr_status),
        .wr_mset   (wr_mset),
        .wr_mclr   (wr_mclr),
        .rdata     (bus_rdata)
    );

    hc_irq_status #(.W(W), .SRC_MASK(SRC_ONLY)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_status),
        .clr_bits (bus_wdata),
        .evt      (evt_pulse),
        .stat_q   (stat_q)
    );

    hc_irq_mask #(.W(W), .EN_MASK(EN_MASK)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_mset),
        .clr_en (wr_mclr),
        .bits   (bus_wdata),
        .mask_q (mask_q)
    );

    logic [W-1:0] live;
    always_comb begin
        live = stat_q & mask_q & ~GATE_ONEHOT;
        irq  = mask_q[GATE] && (|live);
    end
endmodule

// File: rtl/hc_irq_regs_chk.sv
module hc_irq_regs_chk #(
    parameter int unsigned  W        = 32,
    parameter int unsigned  GATE     = 31,
    parameter logic [W-1:0] SRC_MASK = 32'h4000_007F
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] evt_pulse,
    input logic [W-1:0] stat_q,
    input logic [W-1:0] mask_q,
    input logic         irq
);
    localparam logic [W-1:0] SRC_ONLY = SRC_MASK & ~(W'(1) << GATE);
    localparam logic [W-1:0] EN_ALL   = SRC_ONLY | (W'(1) << GATE);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (stat_q == '0 && mask_q == '0 && !irq));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & SRC_ONLY)) |=>
        ((stat_q & $past(evt_pulse & SRC_ONLY)) == $past(evt_pulse & SRC_ONLY)));

    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
        ((stat_q & $past(bus_wdata) & ~$past(evt_pulse)) == '0));

    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=>
        ((mask_q & $past(bus_wdata & EN_ALL)) == $past(bus_wdata & EN_ALL)));

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> ((mask_q & $past(bus_wdata)) == '0));

    a_r7_same_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1 || bus_addr == 2'd2) |-> (bus_rdata == mask_q));

    a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q[GATE] && (stat_q != '0)));

    a_r9_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~SRC_ONLY) == '0) && ((mask_q & ~EN_ALL) == '0));

    a_r9_spare_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind hc_irq_regs hc_irq_regs_chk #(.W(W), .GATE(GATE), .SRC_MASK(SRC_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/tb_hc_irq_regs.sv
module tb_hc_irq_regs;
    localparam logic [31:0] SRC = 32'h4000_007F;
    localparam logic [31:0] ENM = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_pulse = '0;
    logic        irq;

    int unsigned total = 0;
    int unsigned bad = 0;
    bit          done = 1'b0;
    logic [31:0] m_st = '0;
    logic [31:0] m_en = '0;

    always #4 clk = ~clk;

    hc_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] a, input logic [31:0] d, input logic [31:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = ev;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0; bus_wdata = '0;
        if (a == 2'd0) m_st = m_st & ~d;
        m_st = (m_st | ev) & SRC;
        if (a == 2'd1) m_en = (m_en | d) & ENM;
        if (a == 2'd2) m_en = m_en & ~d;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string tag);
        check(tag, {31'd0, irq}, {31'd0, m_en[31] && ((m_st & m_en & 32'h7FFF_FFFF) != 0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rd("R1 status", 2'd0, 32'h0);
        rd("R1 mask", 2'd1, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R9 R10: per-bit event then clear
        for (int i = 0; i < 32; i++) begin
            op(2'd3, 32'hFFFF_FFFF, 32'h1 << i);   // R9: spare index write ignored
            rd("R2 R10 event bit", 2'd0, SRC & (32'h1 << i));
            rd("R9 spare read", 2'd3, 32'h0);
            chk_irq("R8 masked");
            op(2'd0, 32'h0, 32'h0);
            rd("R3 zero write keeps", 2'd0, m_st);
            op(2'd0, 32'h1 << i, 32'h0);
            rd("R3 w1c", 2'd0, 32'h0);
        end

        // R4: clear and event together
        op(2'd0, 32'h0000_0001, 32'h0000_0001);
        rd("R4 event wins", 2'd0, 32'h1);
        op(2'd0, 32'h1, 32'h0);

        // R5 R6 R7: per-bit mask set/clear
        for (int i = 0; i < 32; i++) begin
            op(2'd1, 32'h1 << i, 32'h0);
            rd("R5 set", 2'd1, ENM & (32'h1 << i));
            rd("R7 same via clear index", 2'd2, ENM & (32'h1 << i));
            op(2'd2, 32'h1 << i, 32'h0);
            rd("R6 clear", 2'd1, 32'h0);
        end
        op(2'd1, 32'hFFFF_FFFF, 32'h0);
        op(2'd1, 32'h0, 32'h0);
        op(2'd2, 32'h0, 32'h0);
        rd("R5 R6 zero bits keep", 2'd2, ENM);
        op(2'd2, 32'h0000_0F0F, 32'h0);
        rd("R6 partial clear", 2'd1, ENM & ~32'h0000_0F0F);
        op(2'd2, 32'hFFFF_FFFF, 32'h0);

        // R8: irq truth sweep over status bit, enable bit, gate
        for (int s = 0; s < 32; s++) begin
            if (SRC[s]) begin
                for (int g = 0; g < 2; g++) begin
                    for (int e = 0; e < 2; e++) begin
                        op(2'd1, (g ? 32'h8000_0000 : 32'h0) |
                                 (32'h1 << (e ? s : (s + 1) % 7)), 32'h1 << s);
                        chk_irq("R8 irq");
                        op(2'd0, 32'hFFFF_FFFF, 32'h0);
                        chk_irq("R8 irq after clear");
                        op(2'd2, 32'hFFFF_FFFF, 32'h0);
                    end
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule